// File: doc/BRIEF.md
# Two-Point Gain and Offset Coefficient Calculator

This block turns two averaged, uncalibrated 14-bit converter readings into the pair of coefficients that a linear correction stage applies as `corrected = gain * raw + offset`. One reading is taken on the upper reference, whose ideal code is 0x3000, and one on the lower reference, whose ideal code is 0x1000. The gain coefficient is the ideal span 0x2000 divided by the measured span. It is a 15-bit fraction with 14 fractional bits, so 0x4000 means a gain of 1.0. The offset coefficient moves the upper point onto its ideal code and removes the fixed half-LSB adder of 2 that the correction stage always applies.

The gain comes from a restoring division that resolves one quotient bit per clock, from the most significant bit down. The product of gain and the upper reading is built in the same loop by shift-and-add, so no multiplier is needed. A pulse on `start_i` while idle launches a run. `busy_o` is high while the loop runs. `done_o` pulses once when the coefficients and the error flag are valid. A non-positive span or a gain of 2.0 or more ends the run with `error_o` set.

Top module: `gain_offset_calc`

## Requirements
- R1: While `rst_ni` is low and after its release, `busy_o`, `done_o` and `error_o` are 0 and `gain_o` and `offset_o` are 0.
- R2: `start_i` is accepted only while `busy_o` is 0. It is sampled on a rising edge, and a valid run shows `busy_o` high from that edge until `done_o`. A `start_i` pulse during a run changes neither the result nor its timing.
- R3: When `hi_ref_i - lo_ref_i` is greater than 4096, `gain_o` = floor(2^27 / (hi_ref_i - lo_ref_i)) and `error_o` = 0. `done_o` is high in the cycle after the 16th rising edge following the start edge.
- R4: On a successful run, `offset_o` = (0x3000 - floor(`gain_o` * hi_ref_i / 2^14) - 2) modulo 2^14, read as a 14-bit two's complement number.
- R5: When `hi_ref_i` <= `lo_ref_i`, the block never goes busy. `done_o` and `error_o` are 1 in the cycle right after the start edge, and both coefficients are 0.
- R6: When the span is positive but no more than 4096 (gain of 2.0 or more), the first division step detects it. `done_o` and `error_o` are 1 in the cycle after the first edge following the start edge, and both coefficients are 0.
- R7: `done_o` is high for exactly one cycle. `gain_o`, `offset_o` and `error_o` change only in a cycle where `done_o` is high, and they hold until the next completion.
- R8: The readings 12263 (upper) and 4109 (lower) produce `gain_o` = 16460 and `offset_o` = -33 (0x3FDF).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch a calculation while idle |
| hi_ref_i | input | 14 | Averaged raw reading of the upper (ideal 0x3000) reference |
| lo_ref_i | input | 14 | Averaged raw reading of the lower (ideal 0x1000) reference |
| busy_o | output | 1 | Division loop running |
| done_o | output | 1 | One-cycle completion pulse |
| error_o | output | 1 | Last run failed (non-positive span or gain of 2.0 or more) |
| gain_o | output | 15 | Gain coefficient, 1.14 unsigned fixed point |
| offset_o | output | 14 | Offset coefficient, two's complement |

## Verification
A run ends at one of three fixed points, counted in rising edges after the edge that samples `start_i`: a bad span ends at that same edge, an over-range gain one edge later, and a good run sixteen edges later. For each stimulus the bench computes the latency it expects. It then samples 2 ns after every edge, counts the edges until `done_o` is seen, and compares that count with the expected latency before it compares the coefficients. Afterwards it waits idle cycles and confirms that the outputs hold and that no further pulse appears, including after a start pulse injected in the middle of a run.

// File: rtl/gocal_pkg.sv
package gocal_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } cal_state_e;
endpackage

// File: rtl/gocal_div_step.sv
// One restoring-division step: compare, conditional subtract, shift.
module gocal_div_step #(
  parameter int unsigned DATA_W = 14,
  localparam int unsigned REM_W = DATA_W + 1
) (
  input  logic [REM_W-1:0]  rem_i,
  input  logic [DATA_W-1:0] div_i,
  output logic              bit_o,
  output logic              ovf_o,
  output logic [REM_W-1:0]  rem_o
);
  logic [REM_W-1:0] div_ext, sub, kept;

  always_comb begin
    div_ext = {1'b0, div_i};
    bit_o   = rem_i >= div_ext;
    sub     = rem_i - div_ext;
    kept    = bit_o ? sub : rem_i;
    // remainder still covering the divisor => quotient bit would need to be 2
    ovf_o   = bit_o && (sub >= div_ext);
    rem_o   = REM_W'({kept, 1'b0});
  end
endmodule

// File: rtl/gocal_acc_step.sv
// Shift-and-add product accumulation, driven by the quotient bit just resolved.
module gocal_acc_step #(
  parameter int unsigned DATA_W = 14,
  parameter int unsigned ACC_W  = 30
) (
  input  logic [ACC_W-1:0]  acc_i,
  input  logic [DATA_W-1:0] hi_i,
  input  logic              bit_i,
  output logic [ACC_W-1:0]  acc_o
);
  logic [ACC_W-1:0] sum;

  always_comb begin
    sum   = acc_i + (bit_i ? ACC_W'(hi_i) : '0);
    acc_o = ACC_W'({sum, 1'b0});
  end
endmodule

// File: rtl/gocal_offset.sv
// Offset = ideal high code - scaled product - half-LSB adder, wrapped to DATA_W.
module gocal_offset #(
  parameter int unsigned DATA_W   = 14,
  parameter int unsigned ACC_W    = 30,
  parameter int unsigned IDEAL_HI = 'h3000,
  parameter int unsigned HALF_LSB = 2
) (
  input  logic [ACC_W-1:0]  acc_i,
  output logic [DATA_W-1:0] occ_o
);
  localparam int unsigned SHIFT = DATA_W + 1;
  logic [ACC_W-1:0] scaled, diff;

  always_comb begin
    scaled = acc_i >> SHIFT;
    diff   = ACC_W'(IDEAL_HI) - scaled - ACC_W'(HALF_LSB);
    occ_o  = DATA_W'(diff);
  end
endmodule

// File: rtl/gain_offset_calc.sv
module gain_offset_calc
  import gocal_pkg::*;
#(
  parameter int unsigned DATA_W   = 14,
  parameter int unsigned GAIN_W   = 15,
  parameter int unsigned IDEAL_HI = 'h3000,
  parameter int unsigned IDEAL_LO = 'h1000,
  parameter int unsigned HALF_LSB = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] hi_ref_i,
  input  logic [DATA_W-1:0] lo_ref_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              error_o,
  output logic [GAIN_W-1:0] gain_o,
  output logic [DATA_W-1:0] offset_o
);
  localparam int unsigned SPAN  = IDEAL_HI - IDEAL_LO;
  localparam int unsigned REM_W = DATA_W + 1;
  localparam int unsigned ACC_W = GAIN_W + DATA_W + 1;
  localparam int unsigned CNT_W = $clog2(GAIN_W);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(GAIN_W - 1);

  cal_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] div_q, hi_q;
  logic [REM_W-1:0]  rem_q, rem_nx;
  logic [GAIN_W-1:0] quo_q, gain_q;
  logic [ACC_W-1:0]  acc_q, acc_nx;
  logic [DATA_W-1:0] offset_q, occ;
  logic              err_q, done_q;
  logic              q_bit, ovf;
  logic              span_ok;

  assign span_ok = hi_ref_i > lo_ref_i;

  gocal_div_step #(.DATA_W(DATA_W)) u_div (
    .rem_i(rem_q), .div_i(div_q), .bit_o(q_bit), .ovf_o(ovf), .rem_o(rem_nx)
  );

  gocal_acc_step #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_acc (
    .acc_i(acc_q), .hi_i(hi_q), .bit_i(q_bit), .acc_o(acc_nx)
  );

  gocal_offset #(
    .DATA_W(DATA_W), .ACC_W(ACC_W), .IDEAL_HI(IDEAL_HI), .HALF_LSB(HALF_LSB)
  ) u_off (
    .acc_i(acc_q), .occ_o(occ)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      div_q    <= '0;
      hi_q     <= '0;
      rem_q    <= '0;
      quo_q    <= '0;
      acc_q    <= '0;
      gain_q   <= '0;
      offset_q <= '0;
      err_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (span_ok) begin
              div_q   <= hi_ref_i - lo_ref_i;
              hi_q    <= hi_ref_i;
              rem_q   <= REM_W'(SPAN);
              quo_q   <= '0;
              acc_q   <= '0;
              cnt_q   <= CNT_TOP;
              state_q <= ST_RUN;
            end else begin
              err_q    <= 1'b1;
              gain_q   <= '0;
              offset_q <= '0;
              done_q   <= 1'b1;
            end
          end
        end
        ST_RUN: begin
          quo_q <= {quo_q[GAIN_W-2:0], q_bit};
          rem_q <= rem_nx;
          acc_q <= acc_nx;
          if (ovf) begin
            err_q    <= 1'b1;
            gain_q   <= '0;
            offset_q <= '0;
            done_q   <= 1'b1;
            state_q  <= ST_IDLE;
          end else if (cnt_q == '0) begin
            state_q <= ST_FIN;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_FIN: begin
          gain_q   <= quo_q;
          offset_q <= occ;
          err_q    <= 1'b0;
          done_q   <= 1'b1;
          state_q  <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o   = state_q != ST_IDLE;
  assign done_o   = done_q;
  assign error_o  = err_q;
  assign gain_o   = gain_q;
  assign offset_o = offset_q;

  a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r2_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r2_busy_from_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  a_r5_err_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && error_o) |-> (gain_o == '0 && offset_o == '0));

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(gain_o) && $stable(offset_o) && $stable(error_o)));

  a_r3_rem_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && cnt_q != CNT_TOP) |-> (rem_q < {div_q, 1'b0}));

  a_r6_ovf_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && ovf) |-> (cnt_q == CNT_TOP));
endmodule

// File: tb/sim_gain_offset_calc.sv
module sim_gain_offset_calc;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [13:0] hi_ref_i = '0;
  logic [13:0] lo_ref_i = '0;
  logic        busy_o, done_o, error_o;
  logic [14:0] gain_o;
  logic [13:0] offset_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk_i = ~clk_i;

  gain_offset_calc u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .hi_ref_i(hi_ref_i), .lo_ref_i(lo_ref_i),
    .busy_o(busy_o), .done_o(done_o), .error_o(error_o),
    .gain_o(gain_o), .offset_o(offset_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected results from the requirements
  task automatic model(input int hi, input int lo, output longint g, output longint o,
                       output bit e, output int lat);
    longint d, p;
    g = 0; o = 0; e = 1'b1; lat = 0;
    if (hi > lo) begin
      d = hi - lo;
      if (d <= 4096) lat = 1;
      else begin
        e   = 1'b0;
        lat = 16;
        g   = 134217728 / d;
        p   = g * hi;
        o   = (12288 - (p >> 14) - 2) & 16383;
      end
    end
  endtask

  task automatic run_op(input int hi, input int lo, input bit inject);
    longint eg, eo;
    bit     ee;
    int     elat;
    int     n;
    model(hi, lo, eg, eo, ee, elat);
    hi_ref_i = 14'(hi);
    lo_ref_i = 14'(lo);
    start_i  = 1'b1;
    @(posedge clk_i); #2;
    start_i = 1'b0;
    n = 0;
    if (elat > 0) chk(busy_o == 1'b1, "R2 busy after start", longint'(busy_o), 1);
    else          chk(busy_o == 1'b0, "R5 never busy", longint'(busy_o), 0);
    while (!done_o && n < 40) begin
      if (inject && n == 5) begin
        start_i  = 1'b1;
        hi_ref_i = 14'd100;
        lo_ref_i = 14'd9000;
      end else start_i = 1'b0;
      @(posedge clk_i); #2;
      n++;
    end
    start_i = 1'b0;
    if (ee && elat == 0)      chk(n == elat, "R5 latency", n, elat);
    else if (ee)              chk(n == elat, "R6 latency", n, elat);
    else if (inject)          chk(n == elat, "R2 latency with ignored start", n, elat);
    else                      chk(n == elat, "R3 latency", n, elat);
    chk(error_o == ee, "R5 R6 error flag", longint'(error_o), longint'(ee));
    chk(longint'(gain_o) == eg, "R3 gain", longint'(gain_o), eg);
    chk(longint'(offset_o) == eo, "R4 offset", longint'(offset_o), eo);
    chk(busy_o == 1'b0, "R2 idle at done", longint'(busy_o), 0);
    @(posedge clk_i); #2;
    chk(done_o == 1'b0, "R7 one-cycle done", longint'(done_o), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    int hi, lo;
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk_i);
    #2;
    // R1 reset state
    chk({busy_o, done_o, error_o} == 3'b000, "R1 flags in reset", {busy_o, done_o, error_o}, 0);
    chk(gain_o == '0 && offset_o == '0, "R1 coefficients in reset", gain_o, 0);
    rst_ni = 1'b1;
    @(posedge clk_i); #2;
    chk({busy_o, done_o, error_o} == 3'b000, "R1 flags after reset", {busy_o, done_o, error_o}, 0);

    // R8 worked example: 16460 and -33
    run_op(12263, 4109, 1'b0);
    chk(gain_o == 15'd16460, "R8 gain", gain_o, 16460);
    chk($signed(offset_o) == -14'sd33, "R8 offset", $signed(offset_o), -33);

    // R7 hold over idle cycles
    repeat (6) @(posedge clk_i);
    #2;
    chk(gain_o == 15'd16460 && done_o == 1'b0, "R7 hold", gain_o, 16460);

    // Directed corners
    run_op(5000, 5000, 1'b0);     // R5 equal
    run_op(100, 9000, 1'b0);      // R5 reversed
    run_op(8192, 4096, 1'b0);     // R6 span exactly 4096
    run_op(4097, 1, 1'b0);        // R6 span 4096
    run_op(4098, 1, 1'b0);        // R3 span 4097, largest gain
    run_op(16383, 0, 1'b0);       // R3 smallest gain
    run_op(12288, 4096, 1'b0);    // R3 ideal, gain 0x4000
    chk(gain_o == 15'h4000, "R3 unity gain", gain_o, 16384);
    run_op(12263, 4109, 1'b1);    // R2 start pulse mid-run ignored
    chk(gain_o == 15'd16460, "R2 ignored start result", gain_o, 16460);
    repeat (20) @(posedge clk_i);
    #2;
    chk(done_o == 1'b0 && busy_o == 1'b0, "R2 no second run", {done_o, busy_o}, 0);
    run_op(3000, 1000, 1'b0);     // R6 after a success, flag set again
    run_op(14000, 2000, 1'b0);    // R7 flag cleared by success
    chk(error_o == 1'b0, "R7 error cleared", error_o, 0);

    // Constrained random
    for (int i = 0; i < 60; i++) begin
      if (i % 4 == 0) begin
        hi = int'($urandom % 16384);
        lo = int'($urandom % 16384);
      end else begin
        lo = int'($urandom % 6000);
        hi = lo + 4097 + int'($urandom % (16383 - lo - 4097 + 1));
      end
      run_op(hi, lo, (i % 9) == 3);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule